// File: doc/BRIEF.md
# SPI Register-Access Slave Engine

This block is the serial front end of a register file with 32 entries. An external SPI master (mode 0: sample on the rising SCLK edge, change on the falling edge, MSB first) selects the block by pulling the active-low select low, sends one command byte, then moves any number of data bytes to or from the register file. The command byte names a starting register, a direction and an acknowledge flag. The block turns each complete data byte into a single-cycle strobe on the system-clock side. Registers at or below a configurable FIFO boundary get push or pop strobes. All other registers get write or read strobes.

After each data byte the internal register pointer either advances or stays put. It stays put on the FIFO ports, on one configurable mid-map address and on the last address. It advances everywhere else. While the command byte shifts in, a full-duplex transfer returns a status byte that was captured when select fell. In half-duplex mode the serial output stays off and, on reads, the block drives the data-in line once the command byte has ended. SCLK, select and data-in are taken into a system clock that is at least four times the SCLK rate, through two-flop synchronizers.

Top module: `spi_regif`

## Requirements
- R1: After reset, and at any time while select is high, both output enables are low and no strobe is issued; SCLK activity while select is high has no effect.
- R2: The command byte is the first 8 bits after select falls, sampled on rising SCLK edges MSB first: bits 7..3 give the starting register, bit 1 gives the direction (1 = write, 0 = read), bit 0 is the acknowledge flag, and bit 2 is ignored.
- R3: In full-duplex mode, miso_oe_o is high while selected, and the value of status_i at the select falling edge is shifted out on miso_o MSB first, with each bit valid before the rising edge that samples the matching command bit.
- R4: Registers 0..FIFO_TOP (default 4) are FIFO ports: every data byte produces fifo_push_o (write) or fifo_pop_o (read), and the pointer does not change between bytes.
- R5: From registers FIFO_TOP+1 up to HOLD_ADDR-1 (default 5..19) the pointer increments after each data byte, and at HOLD_ADDR (default 20) it holds.
- R6: From registers HOLD_ADDR+1 up to 30 the pointer increments after each data byte, and at 31 it holds.
- R7: On a write, each complete data byte gives one reg_wr_o pulse with that byte on reg_wdata_o and the current register on reg_addr_o. On a read, the byte shifted out is reg_rdata_i for the current reg_addr_o, loaded at the falling edge that ends the previous byte, and reg_rd_o pulses once the byte has been sent.
- R8: A command with bit 0 set produces exactly one single-cycle ack_pulse_o when host_mode_i is low, and none when host_mode_i is high.
- R9: A data byte cut short by select rising produces no strobe.
- R10: In half-duplex mode miso_oe_o stays low; mosi_oe_o rises only on a read, after the 8th falling SCLK edge, and falls when select rises; on a write mosi_oe_o stays low.
- R11: The duplex mode is taken from half_duplex_i at the select falling edge; a change later in the same transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from master |
| ss_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from master |
| mosi_o | output | 1 | Serial data driven onto the data-in line in half-duplex reads |
| mosi_oe_o | output | 1 | Drive enable for mosi_o |
| miso_o | output | 1 | Serial data to master in full-duplex mode |
| miso_oe_o | output | 1 | Drive enable for miso_o |
| half_duplex_i | input | 1 | Duplex mode select, 1 = half duplex |
| host_mode_i | input | 1 | Suppresses the acknowledge pulse when high |
| status_i | input | 8 | Status byte returned during the command byte |
| reg_addr_o | output | 5 | Current register pointer |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, same cycle |
| reg_wdata_o | output | 8 | Write data for write and push strobes |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| fifo_push_o | output | 1 | FIFO push strobe |
| fifo_pop_o | output | 1 | FIFO pop strobe |
| ack_pulse_o | output | 1 | Single-cycle control-acknowledge pulse |

## Verification
A bit counter that drifts from the byte boundary shows at the ports within one byte. Strobes then appear after the wrong number of SCLK edges, or read data is shifted by one position. A wrong pointer step shows on reg_addr_o in the strobe that follows, so a burst of three bytes across each address range exposes it. A mode latched at the wrong moment shows in the very next SCLK bit, through the enable pair. A lost status capture shows in the first byte returned.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int CMD_WR_BIT = 1;
  localparam int CMD_AK_BIT = 0;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DATA} phase_t;

  // Pointer step after one data byte: FIFO ports, the mid hold address
  // and the top address keep their value; every other address advances.
  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] fifo_top,
    input logic [ADDR_W-1:0] hold_at
  );
    if (a <= fifo_top)  return a;
    if (a == hold_at)   return a;
    if (a == '1)        return a;
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_regif_link.sv
module spi_regif_link
  import spi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sel_n_s,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic              start,
  output logic              stop,
  output logic              fall,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_bit
);
  logic              sclk_q, sel_q, sel, rise;
  logic [DATA_W-1:0] rx_sh, tx_sh;

  assign sel       = ~sel_n_s;
  assign start     = sel & ~sel_q;
  assign stop      = ~sel & sel_q;
  assign rise      = sel & sel_q & sclk_s & ~sclk_q;
  assign fall      = sel & sel_q & ~sclk_s & sclk_q;
  assign rx_byte   = {rx_sh[DATA_W-2:0], mosi_s};
  assign byte_done = rise & (bit_cnt == BIT_W'(DATA_W-1));
  assign tx_bit    = tx_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sel_q   <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel;
      if (start) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= rx_byte;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (load)      tx_sh <= load_val;
      else if (fall) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_regif_ptr.sv
module spi_regif_ptr
  import spi_regif_pkg::*;
#(
  parameter int FIFO_TOP  = 4,
  parameter int HOLD_ADDR = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] FT = ADDR_W'(FIFO_TOP);
  localparam logic [ADDR_W-1:0] HA = ADDR_W'(HOLD_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          addr <= '0;
    else if (load)    addr <= load_addr;
    else if (advance) addr <= step_addr(addr, FT, HA);
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_TOP    = 4,
  parameter int HOLD_ADDR   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              half_duplex_i,
  input  logic              host_mode_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic              fifo_push_o,
  output logic              fifo_pop_o,
  output logic              ack_pulse_o
);
  localparam logic [ADDR_W-1:0] FT = ADDR_W'(FIFO_TOP);

  logic [2:0]        raw_pins, synced;
  logic              sel_start, sel_stop, sclk_fall, byte_done, tx_bit;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_byte, tx_val;
  logic              tx_load, cmd_done, data_done, adv, is_fifo;
  logic              dir_wr, hd_q;
  logic [ADDR_W-1:0] ptr;
  phase_t            phase;

  assign raw_pins = {ss_n_i, sclk_i, mosi_i};

  spi_regif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst (rst), .d (raw_pins), .q (synced)
  );

  spi_regif_link u_link (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (synced[1]),
    .sel_n_s   (synced[2]),
    .mosi_s    (synced[0]),
    .load      (tx_load),
    .load_val  (tx_val),
    .start     (sel_start),
    .stop      (sel_stop),
    .fall      (sclk_fall),
    .bit_cnt   (bit_cnt),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_bit    (tx_bit)
  );

  spi_regif_ptr #(.FIFO_TOP(FIFO_TOP), .HOLD_ADDR(HOLD_ADDR)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd_done),
    .load_addr (rx_byte[DATA_W-1 -: ADDR_W]),
    .advance   (adv),
    .addr      (ptr)
  );

  assign cmd_done  = byte_done & (phase == PH_CMD);
  assign data_done = byte_done & (phase == PH_DATA);
  assign is_fifo   = (ptr <= FT);
  assign adv       = reg_wr_o | reg_rd_o | fifo_push_o | fifo_pop_o;
  // Read data enters the shifter on the falling edge that closes a byte.
  assign tx_load   = sel_start |
                     (sclk_fall & (phase == PH_DATA) & ~dir_wr & (bit_cnt == '0));
  assign tx_val    = sel_start ? status_i : reg_rdata_i;

  assign reg_addr_o = ptr;
  assign mosi_o     = tx_bit;
  assign miso_o     = tx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      dir_wr      <= 1'b0;
      hd_q        <= 1'b0;
      miso_oe_o   <= 1'b0;
      mosi_oe_o   <= 1'b0;
      reg_wdata_o <= '0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      fifo_push_o <= 1'b0;
      fifo_pop_o  <= 1'b0;
      ack_pulse_o <= 1'b0;
    end else begin
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      fifo_push_o <= 1'b0;
      fifo_pop_o  <= 1'b0;
      ack_pulse_o <= 1'b0;
      if (sel_start) begin
        phase     <= PH_CMD;
        hd_q      <= half_duplex_i;
        miso_oe_o <= ~half_duplex_i;
        mosi_oe_o <= 1'b0;
      end else if (sel_stop) begin
        phase     <= PH_IDLE;
        miso_oe_o <= 1'b0;
        mosi_oe_o <= 1'b0;
      end else begin
        if (cmd_done) begin
          dir_wr      <= rx_byte[CMD_WR_BIT];
          ack_pulse_o <= rx_byte[CMD_AK_BIT] & ~host_mode_i;
          phase       <= PH_DATA;
        end
        if (data_done) begin
          reg_wdata_o <= rx_byte;
          reg_wr_o    <= dir_wr & ~is_fifo;
          fifo_push_o <= dir_wr & is_fifo;
          reg_rd_o    <= ~dir_wr & ~is_fifo;
          fifo_pop_o  <= ~dir_wr & is_fifo;
        end
        if (tx_load && hd_q) mosi_oe_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int FIFO_TOP  = 4,
  parameter int HOLD_ADDR = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       ss_n_i,
  input logic       host_mode_i,
  input logic       miso_oe_o,
  input logic       mosi_oe_o,
  input logic [4:0] reg_addr_o,
  input logic       reg_wr_o,
  input logic       reg_rd_o,
  input logic       fifo_push_o,
  input logic       fifo_pop_o,
  input logic       ack_pulse_o
);
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)            cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 1'b1;
  end

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(miso_oe_o && mosi_oe_o)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd6 && ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2) &&
     $past(ss_n_i, 3) && $past(ss_n_i, 4)) |-> (!miso_oe_o && !mosi_oe_o)); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_wr_o, reg_rd_o, fifo_push_o, fifo_pop_o}) <= 1); // R7

  AST_FIFO_RANGE: assert property (@(posedge clk) disable iff (rst)
    (fifo_push_o || fifo_pop_o) |-> (reg_addr_o <= 5'(FIFO_TOP))); // R4

  AST_REG_RANGE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_o || reg_rd_o) |-> (reg_addr_o > 5'(FIFO_TOP))); // R4

  AST_FIFO_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (fifo_push_o || fifo_pop_o) |=> (reg_addr_o == $past(reg_addr_o))); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr_o || reg_rd_o) && reg_addr_o != 5'(HOLD_ADDR) && reg_addr_o != 5'd31)
    |=> (reg_addr_o == $past(reg_addr_o) + 5'd1)); // R5

  AST_PTR_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr_o || reg_rd_o) && reg_addr_o == 5'd31) |=> (reg_addr_o == 5'd31)); // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack_pulse_o |=> !ack_pulse_o); // R8

  AST_ACK_HOST: assert property (@(posedge clk) disable iff (rst)
    ack_pulse_o |-> !$past(host_mode_i)); // R8
endmodule

bind spi_regif spi_regif_chk #(.FIFO_TOP(FIFO_TOP), .HOLD_ADDR(HOLD_ADDR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ss_n_i      (ss_n_i),
  .host_mode_i (host_mode_i),
  .miso_oe_o   (miso_oe_o),
  .mosi_oe_o   (mosi_oe_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wr_o    (reg_wr_o),
  .reg_rd_o    (reg_rd_o),
  .fifo_push_o (fifo_push_o),
  .fifo_pop_o  (fifo_pop_o),
  .ack_pulse_o (ack_pulse_o)
);

// File: tb/sim_spi_regif.sv
module sim_spi_regif;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
  logic       half_duplex_i = 1'b0, host_mode_i = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic       mosi_o, mosi_oe_o, miso_o, miso_oe_o;
  logic [4:0] reg_addr_o;
  logic [7:0] reg_rdata_i, reg_wdata_o;
  logic       reg_wr_o, reg_rd_o, fifo_push_o, fifo_pop_o, ack_pulse_o;

  int nchk = 0, nerr = 0;
  int pops = 0, acks = 0, seen_miso = 0, seen_mosi = 0, lg_n = 0;
  int lg_kind [64];
  int lg_addr [64];
  int lg_data [64];
  logic [7:0] tx_data [8];
  logic [7:0] got_rd [8];
  logic [7:0] got_status, dummy;
  logic       cmd_mosi_oe, flip_mode = 1'b0;

  always #10 clk = ~clk;

  spi_regif u0 (
    .clk, .rst, .sclk_i, .ss_n_i, .mosi_i, .mosi_o, .mosi_oe_o, .miso_o, .miso_oe_o,
    .half_duplex_i, .host_mode_i, .status_i, .reg_addr_o, .reg_rdata_i, .reg_wdata_o,
    .reg_wr_o, .reg_rd_o, .fifo_push_o, .fifo_pop_o, .ack_pulse_o
  );

  // Register model: FIFO ports return A0 plus pops so far, others 40 plus address.
  assign reg_rdata_i = (reg_addr_o <= 5'd4) ? (8'hA0 + pops[7:0]) : (8'h40 + {3'b000, reg_addr_o});

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr_o || reg_rd_o || fifo_push_o || fifo_pop_o) begin
        if (lg_n < 64) begin
          lg_kind[lg_n] = reg_wr_o ? 0 : reg_rd_o ? 1 : fifo_push_o ? 2 : 3;
          lg_addr[lg_n] = int'(reg_addr_o);
          lg_data[lg_n] = int'(reg_wdata_o);
        end
        lg_n++;
      end
      if (fifo_pop_o)  pops++;
      if (ack_pulse_o) acks++;
      if (miso_oe_o)   seen_miso++;
      if (mosi_oe_o)   seen_mosi++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ent(input string tag, input int idx, input int kind, input int addr);
    chk({tag, " kind"}, lg_kind[idx], kind);
    chk({tag, " addr"}, lg_addr[idx], addr);
  endtask

  task automatic shift_byte(input logic [7:0] v, input int nb, output logic [7:0] got, input logic is_cmd);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      mosi_i = v[7-i];
      repeat (HALF) @(negedge clk);
      got[7-i] = mosi_oe_o ? mosi_o : miso_o;
      if (is_cmd && mosi_oe_o) cmd_mosi_oe = 1'b1;
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbytes, input int tail);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    if (flip_mode) half_duplex_i = ~half_duplex_i;
    cmd_mosi_oe = 1'b0;
    shift_byte(cmd, 8, got_status, 1'b1);
    for (int b = 0; b < nbytes; b++) shift_byte(tx_data[b], 8, got_rd[b], 1'b0);
    if (tail > 0) shift_byte(8'hFF, tail, dummy, 1'b0);
    repeat (HALF) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset miso_oe", int'(miso_oe_o), 0);
    chk("R1 reset mosi_oe", int'(mosi_oe_o), 0);
    chk("R1 reset strobes", lg_n, 0);
  endtask

  task automatic t_idle_sclk;
    int n0 = lg_n, m0 = seen_miso + seen_mosi;
    for (int i = 0; i < 12; i++) begin
      mosi_i = i[0];
      repeat (HALF) @(negedge clk); sclk_i = 1'b1;
      repeat (HALF) @(negedge clk); sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk("R1 sclk with select high strobes", lg_n - n0, 0);
    chk("R1 sclk with select high enables", seen_miso + seen_mosi - m0, 0);
  endtask

  task automatic t_fd_write_inc;
    int n0 = lg_n, m0 = seen_miso;
    status_i = 8'hC5;
    tx_data[0] = 8'h11; tx_data[1] = 8'h22; tx_data[2] = 8'h33;
    xfer(8'h2A, 3, 0);   // R2: reg 5, write, no ack
    status_i = 8'h00;
    chk("R3 status byte", int'(got_status), 'hC5);
    chk("R3 miso_oe while selected", int'(seen_miso > m0), 1);
    chk("R5 write count", lg_n - n0, 3);
    for (int k = 0; k < 3; k++) begin
      chk_ent("R5 inc write", n0 + k, 0, 5 + k);
      chk("R7 write data", lg_data[n0 + k], int'(tx_data[k]));
    end
  endtask

  task automatic t_fifo_write;
    int n0 = lg_n;
    tx_data[0] = 8'h5A; tx_data[1] = 8'hA5; tx_data[2] = 8'h3C;
    xfer(8'h12, 3, 0);   // reg 2 write
    chk("R4 push count", lg_n - n0, 3);
    for (int k = 0; k < 3; k++) chk_ent("R4 push hold", n0 + k, 2, 2);
    chk("R4 push data", lg_data[n0 + 2], 'h3C);
  endtask

  task automatic t_hold_mid;
    int n0 = lg_n;
    xfer(8'h9A, 3, 0);   // reg 19 write
    chk_ent("R5 from 19", n0, 0, 19);
    chk_ent("R5 to 20", n0 + 1, 0, 20);
    chk_ent("R5 hold 20", n0 + 2, 0, 20);
  endtask

  task automatic t_hold_top;
    int n0 = lg_n;
    xfer(8'hF2, 3, 0);   // reg 30 write
    chk_ent("R6 from 30", n0, 0, 30);
    chk_ent("R6 to 31", n0 + 1, 0, 31);
    chk_ent("R6 hold 31", n0 + 2, 0, 31);
  endtask

  task automatic t_read_regs;
    int n0 = lg_n;
    xfer(8'h50, 2, 0);   // reg 10 read
    chk("R7 read byte 0", int'(got_rd[0]), 'h4A);
    chk("R7 read byte 1", int'(got_rd[1]), 'h4B);
    chk("R7 read strobe count", lg_n - n0, 2);
    chk_ent("R7 read 10", n0, 1, 10);
    chk_ent("R5 read 11", n0 + 1, 1, 11);
  endtask

  task automatic t_read_fifo;
    int n0 = lg_n, p0 = pops;
    xfer(8'h08, 2, 0);   // reg 1 read
    chk("R4 pop byte 0", int'(got_rd[0]), (8'hA0 + p0) & 8'hFF);
    chk("R4 pop byte 1", int'(got_rd[1]), (8'hA0 + p0 + 1) & 8'hFF);
    chk("R4 pop count", pops - p0, 2);
    chk_ent("R4 pop hold", n0 + 1, 3, 1);
  endtask

  task automatic t_ack;
    int a0 = acks;
    host_mode_i = 1'b0;
    xfer(8'h2B, 0, 0);
    chk("R8 ack pulse device mode", acks - a0, 1);
    a0 = acks;
    host_mode_i = 1'b1;
    xfer(8'h2B, 0, 0);
    host_mode_i = 1'b0;
    chk("R8 ack suppressed host mode", acks - a0, 0);
    a0 = acks;
    xfer(8'h2A, 0, 0);
    chk("R2 no ack when bit0 clear", acks - a0, 0);
  endtask

  task automatic t_partial;
    int n0 = lg_n;
    tx_data[0] = 8'h77;
    xfer(8'h42, 1, 5);   // reg 8 write, one byte plus 5 bits
    chk("R9 partial byte dropped", lg_n - n0, 1);
    chk_ent("R9 full byte kept", n0, 0, 8);
  endtask

  task automatic t_hd_read;
    int m0 = seen_miso, s0 = seen_mosi;
    half_duplex_i = 1'b1;
    xfer(8'h60, 2, 0);   // reg 12 read
    half_duplex_i = 1'b0;
    chk("R10 hd read byte 0", int'(got_rd[0]), 'h4C);
    chk("R10 hd read byte 1", int'(got_rd[1]), 'h4D);
    chk("R10 miso_oe off", seen_miso - m0, 0);
    chk("R10 mosi_oe off in command", int'(cmd_mosi_oe), 0);
    chk("R10 mosi_oe on in data", int'(seen_mosi > s0), 1);
    chk("R10 mosi_oe off after select", int'(mosi_oe_o), 0);
  endtask

  task automatic t_hd_write;
    int n0 = lg_n, s0 = seen_mosi;
    half_duplex_i = 1'b1;
    tx_data[0] = 8'h99;
    xfer(8'h6A, 1, 0);   // reg 13 write
    half_duplex_i = 1'b0;
    chk("R10 hd write no drive", seen_mosi - s0, 0);
    chk_ent("R10 hd write", n0, 0, 13);
    chk("R10 hd write data", lg_data[n0], 'h99);
  endtask

  task automatic t_mode_latch;
    int s0 = seen_mosi;
    status_i = 8'h96;
    flip_mode = 1'b1;
    xfer(8'h50, 1, 0);   // full duplex at select fall, switched after
    flip_mode = 1'b0;
    half_duplex_i = 1'b0;
    status_i = 8'h00;
    chk("R11 status still on miso", int'(got_status), 'h96);
    chk("R11 read still on miso", int'(got_rd[0]), 'h4A);
    chk("R11 no mosi drive", seen_mosi - s0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_idle_sclk();
    t_fd_write_inc();
    t_fifo_write();
    t_hold_mid();
    t_hold_top();
    t_read_regs();
    t_read_fifo();
    t_ack();
    t_partial();
    t_hd_read();
    t_hd_write();
    t_mode_latch();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule